// File: doc/BRIEF.md
# Priority Chip-Select Bank Decoder

This block sits between a bus master and the external memory machines. It compares each 32-bit bus address against eight programmable memory banks, each defined by a base word and an option word. When several banks match, it picks the lowest-numbered one. It then drives a one-hot chip-select for that bank. It also reports which controlling machine owns the cycle: a general-purpose chip-select engine, or programmable engine A or B.

Each bank can be marked read-only. Each bank can also restrict access to certain 3-bit address-type codes, using a per-bank mask. A write to a read-only bank, or a type-code mismatch, raises a violation flag and selects nothing. The decision is captured on a cycle-start strobe and held until a cycle-done strobe, so the owning machine keeps the external control signals for the whole bus cycle.

Top module: `cs_bank_decoder`

## Requirements
- R1: After reset, all outputs are zero and only bank 0 is valid, with base 0, mask 0, read/write access, no type restriction and machine code 0. Any access started after reset therefore selects bank 0 with machine 0.
- R2: A valid bank matches when address bits [31:15] ANDed with option bits [31:15] equal base bits [31:15]. The bank size is set by the mask, from 32 KB up.
- R3: When several valid banks match, the lowest-numbered bank is the one selected.
- R4: A bank whose valid bit (base bit 0) is clear never matches. An address that matches no bank gives cs_o = 0 and viol_o = 0.
- R5: mach_o carries the winning bank's machine field (base bits [3:2]): 0 means general-purpose, 1 means engine A, 2 means engine B, and 3 is reported as 0. mach_o is 0 when nothing is selected.
- R6: A write (wr_i = 1) to a winning bank whose read-only bit (base bit 1) is set raises viol_o, drives no chip-select and does not fall back to a lower-priority bank. A read of that bank selects it normally.
- R7: Address-type check: the access violates when ((at_i XOR base[7:5]) AND opt[7:5]) is nonzero. This raises viol_o with no chip-select and no fallback.
- R8: The decision is captured at the clock edge where cyc_start_i is high while idle. It is held unchanged until the edge where cyc_done_i is high, after which all outputs are zero.
- R9: Register writes (reg_we_i, reg_bank_i, reg_opt_i = 1 for the option word, reg_wdata_i) take effect at the clock edge. They never alter a decision already held, and they apply to the next cycle.
- R10: cyc_start_i during a held cycle is ignored. cyc_done_i while idle is ignored.
- R11: cs_o is zero or one-hot, and viol_o is never high together with a chip-select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 32 | Bus address |
| wr_i | input | 1 | 1 = write access |
| at_i | input | 3 | Address-type code |
| cyc_start_i | input | 1 | Start of bus cycle, captures the decision |
| cyc_done_i | input | 1 | End of bus cycle, releases the decision |
| reg_we_i | input | 1 | Register write enable |
| reg_bank_i | input | 3 | Bank addressed by the register write |
| reg_opt_i | input | 1 | 0 = base word, 1 = option word |
| reg_wdata_i | input | 32 | Register write data |
| cs_o | output | 8 | One-hot chip-select, bit n for bank n |
| mach_o | output | 2 | Owning machine code |
| viol_o | output | 1 | Protection violation on the held cycle |

## Verification
The assertions assume that cyc_start_i and cyc_done_i are single-cycle pulses. They also assume that a cycle-done pulse follows each accepted start before the next start is meant to count. The stimulus always pulses start once, waits, then pulses done once. Deliberate extra starts inside a held cycle are the only departure, and they exercise R10. Register writes are issued both between cycles and inside held cycles, so a write never has to be ordered against the capture edge beyond what R9 defines.

// File: rtl/cs_bank_decoder.sv
module cs_bank_decoder #(
  parameter int NB = 8,
  parameter int AW = 32,
  parameter int LSB = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         addr_i,
  input  logic                  wr_i,
  input  logic [2:0]            at_i,
  input  logic                  cyc_start_i,
  input  logic                  cyc_done_i,
  input  logic                  reg_we_i,
  input  logic [$clog2(NB)-1:0] reg_bank_i,
  input  logic                  reg_opt_i,
  input  logic [AW-1:0]         reg_wdata_i,
  output logic [NB-1:0]         cs_o,
  output logic [1:0]            mach_o,
  output logic                  viol_o
);
  localparam int IW = $clog2(NB);
  localparam int CW = AW - LSB;

  logic [AW-1:0] base_q [NB];
  logic [AW-1:0] opt_q  [NB];
  logic [NB-1:0] match;
  logic          hit, bad, busy_q;
  logic [IW-1:0] win;
  logic [1:0]    mfield;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin
        base_q[i] <= (i == 0) ? {{(AW-1){1'b0}}, 1'b1} : '0;
        opt_q[i]  <= '0;
      end
    end else if (reg_we_i) begin
      if (reg_opt_i) opt_q[reg_bank_i]  <= reg_wdata_i;
      else           base_q[reg_bank_i] <= reg_wdata_i;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_cmp
    assign match[g] = base_q[g][0] &&
      ((addr_i[AW-1:LSB] & opt_q[g][AW-1:LSB]) == base_q[g][AW-1:LSB]);
  end

  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int i = NB-1; i >= 0; i--)
      if (match[i]) begin
        hit = 1'b1;
        win = IW'(i);
      end
  end

  assign bad    = (wr_i && base_q[win][1]) ||
                  (((at_i ^ base_q[win][7:5]) & opt_q[win][7:5]) != 3'b000);
  assign mfield = (base_q[win][3:2] == 2'd3) ? 2'd0 : base_q[win][3:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cs_o   <= '0;
      mach_o <= '0;
      viol_o <= 1'b0;
    end else if (busy_q) begin
      if (cyc_done_i) begin
        busy_q <= 1'b0;
        cs_o   <= '0;
        mach_o <= '0;
        viol_o <= 1'b0;
      end
    end else if (cyc_start_i) begin
      busy_q <= 1'b1;
      cs_o   <= (hit && !bad) ? (NB'(1) << win) : '0;
      mach_o <= (hit && !bad) ? mfield : 2'd0;
      viol_o <= hit && bad;
    end
  end

  p_cs_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_o));
  p_viol_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> cs_o == '0);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !cyc_done_i |=> $stable(cs_o) && $stable(mach_o) && $stable(viol_o));
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && cyc_done_i |=> cs_o == '0 && mach_o == 2'd0 && !viol_o);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && !cyc_start_i |=> cs_o == '0 && !viol_o);
endmodule

// File: tb/tb_cs_bank_decoder.sv
module tb_cs_bank_decoder;
  logic clk = 0, rst_n = 0;
  logic [31:0] addr = 0, wdata = 0;
  logic wr = 0, start = 0, done = 0, we = 0, opt = 0;
  logic [2:0] at = 0, bank = 0;
  logic [7:0] cs;
  logic [1:0] mach;
  logic viol;
  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit finished = 0;

  always #2 clk = ~clk;

  cs_bank_decoder dut (.clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_i(wr), .at_i(at),
    .cyc_start_i(start), .cyc_done_i(done), .reg_we_i(we), .reg_bank_i(bank),
    .reg_opt_i(opt), .reg_wdata_i(wdata), .cs_o(cs), .mach_o(mach), .viol_o(viol));

  logic [31:0] mb [8];
  logic [31:0] mo [8];
  logic [7:0] e_cs;
  logic [1:0] e_mach;
  logic e_viol, e_busy;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin mb[i] = (i == 0) ? 32'h1 : 0; mo[i] = 0; end
      e_cs = 0; e_mach = 0; e_viol = 0; e_busy = 0;
    end else begin
      if (e_busy) begin
        if (done) begin e_busy = 0; e_cs = 0; e_mach = 0; e_viol = 0; end
      end else if (start) begin
        int w;
        w = -1;
        for (int i = 7; i >= 0; i--)
          if (mb[i][0] && ((addr[31:15] & mo[i][31:15]) == mb[i][31:15])) w = i;
        e_busy = 1; e_cs = 0; e_mach = 0; e_viol = 0;
        if (w >= 0) begin
          if ((wr && mb[w][1]) || (((at ^ mb[w][7:5]) & mo[w][7:5]) != 0)) e_viol = 1;
          else begin
            e_cs = 8'(1 << w);
            e_mach = (mb[w][3:2] == 3) ? 2'd0 : mb[w][3:2];
          end
        end
      end
      if (we) begin if (opt) mo[bank] = wdata; else mb[bank] = wdata; end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished)
    chk(cur_req, {21'b0, viol, mach, cs}, {21'b0, e_viol, e_mach, e_cs});

  task automatic wreg(int b, bit o, logic [31:0] d);
    @(negedge clk); we = 1; bank = 3'(b); opt = o; wdata = d;
    @(negedge clk); we = 0;
  endtask

  function automatic logic [31:0] bw(logic [31:0] a, bit ro, int m, int atv, bit v);
    return {a[31:15], 7'b0, 3'(atv), 1'b0, 2'(m), ro, v};
  endfunction

  task automatic acc(logic [31:0] a, bit w, int t);
    @(negedge clk); addr = a; wr = w; at = 3'(t); start = 1;
    @(negedge clk); start = 0;
    @(negedge clk);
    @(negedge clk); done = 1;
    @(negedge clk); done = 0;
  endtask

  task automatic summary();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {21'b0, viol, mach, cs}, 32'h0);
    cur_req = "R1"; acc(32'h1234_5678, 1, 7);
    cur_req = "R2";
    wreg(0, 1, 32'hFFFF_8000);
    wreg(2, 0, bw(32'h4000_0000, 0, 1, 0, 1)); wreg(2, 1, 32'hF000_0000);
    acc(32'h0000_7FFF, 0, 0); acc(32'h4ABC_0000, 0, 0);
    cur_req = "R4"; acc(32'h0000_8000, 0, 0);
    cur_req = "R3";
    wreg(5, 0, bw(32'h4000_0000, 0, 2, 0, 1)); wreg(5, 1, 32'hFFF0_0000);
    acc(32'h4001_0000, 0, 0);
    cur_req = "R4"; wreg(2, 0, bw(32'h4000_0000, 0, 1, 0, 0));
    acc(32'h4001_0000, 0, 0); acc(32'h4100_0000, 0, 0);
    cur_req = "R5"; wreg(7, 0, bw(32'hE000_0000, 0, 3, 0, 1)); wreg(7, 1, 32'hF000_0000);
    acc(32'hE000_0000, 0, 0);
    cur_req = "R6";
    wreg(3, 0, bw(32'h8000_0000, 1, 1, 0, 1)); wreg(3, 1, 32'hF000_0000);
    wreg(6, 0, bw(32'h8000_0000, 0, 2, 0, 1)); wreg(6, 1, 32'hF000_0000);
    acc(32'h8000_1000, 1, 0); acc(32'h8000_1000, 0, 0);
    cur_req = "R7";
    wreg(4, 0, bw(32'hC000_0000, 0, 2, 5, 1)); wreg(4, 1, 32'hF000_00E0 & 32'hF000_0080);
    acc(32'hC000_0000, 0, 4); acc(32'hC000_0000, 0, 1); acc(32'hC000_0000, 0, 6);
    cur_req = "R8";
    @(negedge clk); addr = 32'h4000_0000; wr = 0; at = 0; start = 1;
    @(negedge clk); start = 0; addr = 32'hC000_0000;
    repeat (3) @(negedge clk);
    cur_req = "R10"; start = 1; addr = 32'h8000_0000;
    @(negedge clk); start = 0;
    cur_req = "R9"; we = 1; bank = 5; opt = 0; wdata = bw(32'h4000_0000, 1, 2, 0, 1);
    @(negedge clk); we = 0; wr = 1;
    @(negedge clk); done = 1;
    @(negedge clk); done = 0;
    cur_req = "R10"; done = 1; @(negedge clk); done = 0;
    cur_req = "R9"; acc(32'h4000_0000, 1, 0);
    cur_req = "R11";
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 2) == 0)
        wreg($urandom_range(0, 7), $urandom_range(0, 1),
             {$urandom_range(0, 3) == 0 ? 4'h0 : 4'($urandom), 28'($urandom)});
      acc({$urandom_range(0, 15) < 12 ? 4'($urandom_range(0, 15)) : 4'h4, 28'($urandom)},
          $urandom_range(0, 1), $urandom_range(0, 7));
    end
    summary();
  end

  initial begin
    #400000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
    end
  end
endmodule